// File: doc/BRIEF.md
# Quad DAC Serial Command Front-End

This block is the digital control logic for a four-channel digital-to-analog converter. A host frames a serial word with an active-low chip-select/load strobe and shifts bits in, MSB first, on rising serial-clock edges. The bits enter a 32-bit shift register. When the strobe returns high, the 24 most recently shifted bits are read as an operation: a 4-bit opcode, a 4-bit channel selector and a 16-bit code.

Each channel has two registers. A staging register holds a written code. A live register holds the code that the converter uses. Each channel also has a sleep flag. A host may send 24-bit words, or 32-bit words that carry 8 leading filler bits. The most significant bit of the shift register is driven out on falling serial-clock edges. Because of this, 32-bit words pass unchanged to a second device in a chain.

The serial pins are oversampled in the system clock domain, so the serial clock must run well below the system clock. Each level of the serial clock must be held for at least two system clocks.

Top module: `qdac_serial_frontend`

## Requirements
- R1: A synchronous reset clears every staging and live code to zero, clears every sleep flag (all channels awake) and drives the chain output low.
- R2: While chip-select is high, serial-clock and data activity is ignored. The shift register contents and the chain output do not change, and a later empty strobe replays the previously captured word.
- R3: A 24-bit word is decoded MSB first as opcode (bits 23..20), selector (bits 19..16) and code (bits 15..0).
- R4: In a 32-bit word, the first 8 bits have no effect. Only the last 24 bits shifted are decoded.
- R5: Opcode 0000 loads the code into the selected staging register and leaves the live code and the sleep flag unchanged.
- R6: Opcode 0001 copies the selected staging register into its live register and clears that channel's sleep flag.
- R7: Opcode 0010 loads the code into the selected staging register and copies staging to live on all four channels in the same action, waking all channels. The selected channel's live register receives the new code.
- R8: Opcode 0011 loads the code into both the staging and live registers of the selected channel and wakes it.
- R9: Opcode 0100 sets the sleep flag of the selected channel. Only opcodes 0001, 0010 or 0011 acting on that channel clear the flag. Opcode 0000 does not clear it.
- R10: Selector 0000, 0001, 0010 and 0011 pick channels A, B, C and D. Selector 1111 picks all four channels.
- R11: Opcode 1111 (no operation), any other opcode, and any selector other than those in R10 leave all state unchanged.
- R12: The chain output presents shift-register bit 31, updated on each falling serial-clock edge while chip-select is low. During a following 32-bit frame, the output therefore replays the previous 32-bit word bit for bit.
- R13: State changes only in response to a chip-select rising edge. Outputs show the result from the first system clock edge that samples chip-select high after it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select / load strobe, active low, rising edge executes |
| sck | input | 1 | Serial clock, oversampled |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Daisy-chain serial data out |
| dac_code | output | NUM_CH*CODE_W | Live codes, channel i at bits i*CODE_W upward |
| pwr_dn | output | NUM_CH | Per-channel sleep flags |

## Verification
Opcode 0010 makes a staging-register write and a staging-to-live transfer happen on the same clock edge. The write targets one channel, while the transfer covers every channel. The bench provokes this by staging different codes on two channels, putting one of them to sleep, and then issuing 0010 to the remaining channel. It then checks that the addressed channel's live code is the fresh word and not the stale staging value. It also checks that the other channels pick up what they had staged and that every sleep flag clears. Write-and-update (0011) with the all-channels selector is checked the same way. There, the staging and live registers on all four channels must show the same new code.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int OP_W  = 4;
  localparam int SEL_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_STAGE      = 4'b0000,
    OP_COMMIT     = 4'b0001,
    OP_STAGE_ALL  = 4'b0010,
    OP_STAGE_LIVE = 4'b0011,
    OP_SLEEP      = 4'b0100,
    OP_IDLE       = 4'b1111
  } op_e;

  localparam logic [SEL_W-1:0] SEL_EVERY = 4'b1111;
endpackage

// File: rtl/qdac_shift_in.sv
module qdac_shift_in #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_en,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi,
  output logic [FRAME_W-1:0] shreg,
  output logic               sdo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (capture_en && sck_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo <= 1'b0;
    end else if (capture_en && sck_fall) begin
      sdo <= shreg[FRAME_W-1];
    end
  end
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16,
  parameter int WORD_W = OP_W + SEL_W + CODE_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              load,
  output logic [NUM_CH-1:0] stage_en,
  output logic [NUM_CH-1:0] commit_en,
  output logic [NUM_CH-1:0] sleep_en,
  output logic [CODE_W-1:0] code
);
  logic [OP_W-1:0]   op;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] hit;
  logic              sel_ok;

  assign op   = word[WORD_W-1 -: OP_W];
  assign sel  = word[WORD_W-OP_W-1 -: SEL_W];
  assign code = word[CODE_W-1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_hit
      assign hit[g] = (sel == SEL_EVERY) || (int'(sel) == g);
    end
  endgenerate

  assign sel_ok = (sel == SEL_EVERY) || (int'(sel) < NUM_CH);

  always_comb begin
    stage_en  = '0;
    commit_en = '0;
    sleep_en  = '0;
    if (load && sel_ok) begin
      unique case (op)
        OP_STAGE:      stage_en = hit;
        OP_COMMIT:     commit_en = hit;
        OP_STAGE_ALL: begin
          stage_en  = hit;
          commit_en = '1;
        end
        OP_STAGE_LIVE: begin
          stage_en  = hit;
          commit_en = hit;
        end
        OP_SLEEP:      sleep_en = hit;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        stage_en,
  input  logic [NUM_CH-1:0]        commit_en,
  input  logic [NUM_CH-1:0]        sleep_en,
  input  logic [CODE_W-1:0]        code,
  output logic [NUM_CH*CODE_W-1:0] live_flat,
  output logic [NUM_CH-1:0]        asleep
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [CODE_W-1:0] staged;
      logic [CODE_W-1:0] live;

      always_ff @(posedge clk) begin
        if (rst) begin
          staged <= '0;
          live   <= '0;
          asleep[g] <= 1'b0;
        end else begin
          if (stage_en[g]) staged <= code;
          if (commit_en[g]) begin
            // a same-edge write is forwarded to the live register
            live      <= stage_en[g] ? code : staged;
            asleep[g] <= 1'b0;
          end else if (sleep_en[g]) begin
            asleep[g] <= 1'b1;
          end
        end
      end

      assign live_flat[g*CODE_W +: CODE_W] = live;
    end
  endgenerate
endmodule

// File: rtl/qdac_serial_frontend.sv
module qdac_serial_frontend
  import qdac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 16,
  parameter int FRAME_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     sck,
  input  logic                     sdi,
  output logic                     sdo,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        pwr_dn
);
  localparam int WORD_W = OP_W + SEL_W + CODE_W;

  logic               sck_q;
  logic               cs_q;
  logic               sck_rise;
  logic               sck_fall;
  logic               load_stb;
  logic [FRAME_W-1:0] shreg;
  logic [NUM_CH-1:0]  stage_en;
  logic [NUM_CH-1:0]  commit_en;
  logic [NUM_CH-1:0]  sleep_en;
  logic [CODE_W-1:0]  code;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
  assign load_stb = cs_n & ~cs_q;

  qdac_shift_in #(.FRAME_W(FRAME_W)) shift_i (
    .clk        (clk),
    .rst        (rst),
    .capture_en (~cs_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sdi        (sdi),
    .shreg      (shreg),
    .sdo        (sdo)
  );

  qdac_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)) decode_i (
    .word      (shreg[WORD_W-1:0]),
    .load      (load_stb),
    .stage_en  (stage_en),
    .commit_en (commit_en),
    .sleep_en  (sleep_en),
    .code      (code)
  );

  qdac_chan_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .stage_en  (stage_en),
    .commit_en (commit_en),
    .sleep_en  (sleep_en),
    .code      (code),
    .live_flat (dac_code),
    .asleep    (pwr_dn)
  );
endmodule

// File: rtl/qdac_serial_frontend_chk.sv
module qdac_serial_frontend_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_n,
  input logic                     sdo,
  input logic [NUM_CH*CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]        pwr_dn
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dac_code == '0 && pwr_dn == '0 && sdo == 1'b0));

  assert_sdo_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> $stable(sdo));

  assert_sleep_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    ((pwr_dn & ~$past(pwr_dn)) != '0) |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_code_needs_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_quiet_when_high_R13: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |=> ($stable(dac_code) && $stable(pwr_dn)));
endmodule

bind qdac_serial_frontend qdac_serial_frontend_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .sdo      (sdo),
  .dac_code (dac_code),
  .pwr_dn   (pwr_dn)
);

// File: tb/qdac_serial_frontend_tb.sv
`timescale 1ns/1ps
module qdac_serial_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [63:0] dac_code;
  logic [3:0]  pwr_dn;

  int checks = 0;
  int errors = 0;
  logic [31:0] cap;

  always #10 clk = ~clk;

  qdac_serial_frontend dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .dac_code(dac_code), .pwr_dn(pwr_dn)
  );

  typedef struct packed {
    logic [31:0] frame;
    logic        long32;
    logic [63:0] codes;   // {D, C, B, A}
    logic [3:0]  sleep;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 1'b0, 64'h0000_0000_0000_0000, 4'h0},
    '{32'h0010_0000, 1'b0, 64'h0000_0000_0000_1234, 4'h0},
    '{32'hFF31_BEEF, 1'b1, 64'h0000_0000_BEEF_1234, 4'h0},
    '{32'h0042_0000, 1'b0, 64'h0000_0000_BEEF_1234, 4'h4},
    '{32'h0002_5555, 1'b0, 64'h0000_0000_BEEF_1234, 4'h4},
    '{32'h0023_7777, 1'b0, 64'h7777_5555_BEEF_1234, 4'h0},
    '{32'h004F_0000, 1'b0, 64'h7777_5555_BEEF_1234, 4'hF},
    '{32'h003F_0F0F, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0},
    '{32'h0050_AAAA, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0},
    '{32'h0004_AAAA, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0},
    '{32'h0010_0000, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0},
    '{32'h00F0_9999, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0},
    '{32'h0030_CAFE, 1'b1, 64'h0F0F_0F0F_0F0F_CAFE, 4'h0},
    '{32'h0040_0000, 1'b0, 64'h0F0F_0F0F_0F0F_CAFE, 4'h1},
    '{32'h0000_1111, 1'b0, 64'h0F0F_0F0F_0F0F_CAFE, 4'h1},
    '{32'h0010_0000, 1'b0, 64'h0F0F_0F0F_0F0F_1111, 4'h0}
  };

  localparam string TAGS [NV] = '{
    "R5 R3", "R6 R13", "R4 R8", "R9", "R5 R9", "R7", "R9 R10", "R8 R10",
    "R11", "R11", "R11 R6", "R11", "R4 R8", "R9", "R9 R5", "R6 R9"
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // shift n bits MSB first; cs_n is left as set by caller
  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sdi = bits[n-1-k];
      repeat (2) @(negedge clk);
      cap[n-1-k] = sdo;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input logic long32);
    @(negedge clk);
    cs_n = 1'b0;
    shift_bits(bits, long32 ? 32 : 24);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic sdo_before;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 codes", dac_code, 64'h0);
    chk("R1 sleep", {60'h0, pwr_dn}, 64'h0);
    chk("R1 sdo", {63'h0, sdo}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].frame, VECS[i].long32);
      chk({TAGS[i], " codes"}, dac_code, VECS[i].codes);
      chk({TAGS[i], " sleep"}, {60'h0, pwr_dn}, {60'h0, VECS[i].sleep});
    end

    // R2: activity with cs high is ignored, empty strobe replays last word
    send(32'h0030_2222, 1'b0);
    send(32'h0031_3333, 1'b0);
    sdo_before = sdo;
    shift_bits(32'h0030_4444, 24);
    chk("R2 sdo held", {63'h0, sdo}, {63'h0, sdo_before});
    chk("R2 codes held", dac_code, 64'h0F0F_0F0F_3333_2222);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 replay", dac_code, 64'h0F0F_0F0F_3333_2222);

    // R12: daisy chain pass-through of a 32-bit word
    send(32'hA532_6789, 1'b1);
    chk("R12 first bit", {63'h0, sdo}, 64'h1);
    chk("R8 chan C", dac_code, 64'h0F0F_6789_3333_2222);
    send(32'h00F0_0000, 1'b1);
    chk("R12 stream", {32'h0, cap}, 64'hA532_6789);
    chk("R11 noop", dac_code, 64'h0F0F_6789_3333_2222);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset codes", dac_code, 64'h0);
    chk("R1 re-reset sdo", {63'h0, sdo}, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule